// File: doc/BRIEF.md
# Stuck-Low Data Line Watchdog for an I2C Target

This block guards an I2C target against a controller that stops clocking while the target is driving the data line low. When that happens, the controller cannot issue a new START, so the bus stays wedged. The watchdog samples the data line at a programmable interval. It keeps a count of suspicious low samples, and a sample is suspicious only while the host side is powered. If three suspicious samples arrive in a row with no completed write transaction between them, the block pulses a reset to the target and bumps a saturating event counter.

The sample interval is set in clock cycles by a configuration input. At a 100 MHz clock, a setting of about 70,000,000 gives the intended interval of roughly 700 ms. The interval must be longer than the longest transaction the controller performs. A bench can use very short intervals.

When the target is initialised, the watchdog restarts its interval timer and clears its low count. If the data line is low at that moment, it also asks a separate sequencer to drive a STOP condition onto the bus.

Top module: `sda_watchdog`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `recover_rst` and `unwedge_req` are 0 and `recover_cnt` is 0.
- R2: Sampling happens every `interval` clock cycles, counted from reset release, an `init_req`, or a recovery. An `interval` of 0 behaves as 1.
- R3: A sample with `host_on` low or `sda_in` high clears the low count.
- R4: The third consecutive low sample taken with `host_on` high sets `recover_rst` for exactly one cycle, in the cycle after that sample. In the same edge, `recover_cnt` increases by one.
- R5: A cycle with `wr_done` high clears the low count. A sample in that same cycle is ignored, so `recover_rst` stays 0 in the following cycle.
- R6: After a recovery, the low count is zero and the interval timer restarts. With the data line held low and `host_on` high, the next recovery comes 3*`interval` cycles after the previous one.
- R7: `recover_cnt` saturates at its all-ones value and never wraps. It changes only together with `recover_rst`.
- R8: `init_req` takes priority over sampling and over `wr_done`. It clears the low count and restarts the timer. In the next cycle, `unwedge_req` is a one-cycle pulse if `sda_in` was low when `init_req` was taken, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval | input | TICK_W | Sample interval in clock cycles (0 acts as 1) |
| init_req | input | 1 | Target initialisation event |
| sda_in | input | 1 | Synchronised level of the data line |
| host_on | input | 1 | Host side is powered |
| wr_done | input | 1 | Target reports a completed write transaction |
| recover_rst | output | 1 | One-cycle reset pulse to the target |
| unwedge_req | output | 1 | One-cycle request to generate a STOP condition |
| recover_cnt | output | CNT_W | Saturating count of recoveries |

## Verification
The assertions assume that `sda_in`, `host_on`, `wr_done` and `init_req` are already synchronous to `clk`. They also assume that `interval` changes only between samples; the checks never depend on the exact timing of such a change. The stimulus drives every input half a cycle away from the active edge. Random intervals are kept between 1 and 5, so many recoveries and many cleared low runs occur within a short run. `wr_done` and `init_req` are kept sparse so that full three-sample low runs still happen often.

// File: rtl/sda_watchdog.sv
module sda_watchdog #(
  parameter int TICK_W = 28,
  parameter int CNT_W  = 16,
  parameter int LOW_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] interval,
  input  logic              init_req,
  input  logic              sda_in,
  input  logic              host_on,
  input  logic              wr_done,
  output logic              recover_rst,
  output logic              unwedge_req,
  output logic [CNT_W-1:0]  recover_cnt
);
  localparam int LW = $clog2(LOW_LIMIT + 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(LOW_LIMIT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [TICK_W-1:0] presc;
  logic [LW-1:0]     low_cnt;

  wire [TICK_W-1:0] last   = (interval == '0) ? '0 : interval - 1'b1;
  wire              sample = presc >= last;
  wire              bad    = host_on && !sda_in;
  wire              fire   = sample && !wr_done && bad && (low_cnt == LOW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc       <= '0;
      low_cnt     <= '0;
      recover_rst <= 1'b0;
      unwedge_req <= 1'b0;
      recover_cnt <= '0;
    end else if (init_req) begin
      presc       <= '0;
      low_cnt     <= '0;
      recover_rst <= 1'b0;
      unwedge_req <= !sda_in;
    end else begin
      unwedge_req <= 1'b0;
      recover_rst <= fire;
      presc       <= sample ? '0 : presc + 1'b1;
      if (wr_done || (sample && (!bad || fire)))
        low_cnt <= '0;
      else if (sample)
        low_cnt <= low_cnt + 1'b1;
      if (fire && recover_cnt != CNT_MAX)
        recover_cnt <= recover_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sda_watchdog_chk.sv
module sda_watchdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_req,
  input logic             sda_in,
  input logic             host_on,
  input logic             wr_done,
  input logic             recover_rst,
  input logic             unwedge_req,
  input logic [CNT_W-1:0] recover_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    recover_rst |=> !recover_rst);

  a_r3_needs_low_powered: assert property (@(posedge clk) disable iff (!rst_n)
    recover_rst |-> ($past(host_on) && !$past(sda_in) && !$past(init_req)));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    recover_rst |-> ((recover_cnt == $past(recover_cnt) + 1'b1) ||
                     (recover_cnt == CNT_MAX && $past(recover_cnt) == CNT_MAX)));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (recover_cnt != $past(recover_cnt)) |-> recover_rst);

  a_r5_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !recover_rst);

  a_r8_unwedge_cause: assert property (@(posedge clk) disable iff (!rst_n)
    unwedge_req |-> ($past(init_req) && !$past(sda_in)));

  a_r8_unwedge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    unwedge_req |=> !unwedge_req || $past(init_req));
endmodule

bind sda_watchdog sda_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_req(init_req), .sda_in(sda_in),
  .host_on(host_on), .wr_done(wr_done), .recover_rst(recover_rst),
  .unwedge_req(unwedge_req), .recover_cnt(recover_cnt)
);

// File: tb/sda_watchdog_test.sv
module sda_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] interval = 8'd4;
  logic init_req = 0, sda_in = 1, host_on = 1, wr_done = 0;
  logic recover_rst, unwedge_req;
  logic [CW-1:0] recover_cnt;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";

  int m_presc = 0, m_low = 0, m_cnt = 0;
  bit m_rec = 0, m_unw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sda_watchdog #(.TICK_W(TW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .interval(interval), .init_req(init_req),
    .sda_in(sda_in), .host_on(host_on), .wr_done(wr_done),
    .recover_rst(recover_rst), .unwedge_req(unwedge_req), .recover_cnt(recover_cnt)
  );

  function automatic int last_of(int iv);
    return (iv == 0) ? 0 : iv - 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_presc = 0; m_low = 0; m_cnt = 0; m_rec = 0; m_unw = 0;
    end else if (init_req) begin
      m_presc = 0; m_low = 0; m_rec = 0; m_unw = !sda_in;
    end else begin
      bit smp;
      smp = m_presc >= last_of(interval);
      m_presc = smp ? 0 : m_presc + 1;
      m_unw = 0; m_rec = 0;
      if (wr_done) m_low = 0;
      else if (smp) begin
        if (!host_on || sda_in) m_low = 0;
        else if (m_low == 2) begin
          m_low = 0; m_rec = 1;
          if (m_cnt != 15) m_cnt++;
        end else m_low++;
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  task automatic cmp_model();
    chk(recover_rst == m_rec, {tag, " recover_rst"}, recover_rst, m_rec);
    chk(unwedge_req == m_unw, {tag, " unwedge_req"}, unwedge_req, m_unw);
    chk(recover_cnt == m_cnt, {tag, " recover_cnt"}, recover_cnt, m_cnt);
  endtask

  task automatic step();
    @(negedge clk);
    cmp_model();
  endtask

  task automatic done_summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    done_summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(recover_rst == 0 && unwedge_req == 0 && recover_cnt == 0, "R1 in reset", recover_cnt, 0);
    rst_n = 1;
    step();
    chk(recover_rst == 0 && unwedge_req == 0 && recover_cnt == 0, "R1 after reset", recover_cnt, 0);

    // R8: init with line low, then high
    tag = "R8";
    sda_in = 0; init_req = 1; step(); init_req = 0; sda_in = 1;
    chk(unwedge_req == 1, "R8 unwedge on low", unwedge_req, 1);
    step();
    chk(unwedge_req == 0, "R8 unwedge one cycle", unwedge_req, 0);
    init_req = 1; step(); init_req = 0;
    chk(unwedge_req == 0, "R8 no unwedge on high", unwedge_req, 0);

    // R2/R4: interval 4, line low, recovery on 12th cycle after init
    tag = "R4";
    interval = 4; host_on = 1; sda_in = 0; init_req = 1; step(); init_req = 0;
    for (int i = 1; i <= 12; i++) begin
      step();
      chk(recover_rst == (i == 12), "R2 R4 recovery timing", recover_rst, i == 12);
    end
    chk(recover_cnt == 1, "R4 count step", recover_cnt, 1);
    step();
    chk(recover_rst == 0, "R4 single pulse", recover_rst, 0);

    // R6: next recovery 3*interval later
    tag = "R6";
    for (int i = 2; i <= 12; i++) begin
      step();
      chk(recover_rst == (i == 12), "R6 restart timing", recover_rst, i == 12);
    end
    chk(recover_cnt == 2, "R6 second count", recover_cnt, 2);

    // R5: write done in the cycle of the third sample suppresses recovery
    tag = "R5";
    init_req = 1; step(); init_req = 0;
    for (int i = 1; i <= 11; i++) step();
    wr_done = 1; step(); wr_done = 0;
    chk(recover_rst == 0, "R5 done blocks recovery", recover_rst, 0);
    for (int i = 1; i <= 8; i++) step();
    chk(recover_rst == 0 && recover_cnt == 2, "R5 count restarted", recover_cnt, 2);

    // R3: host off clears
    tag = "R3";
    init_req = 1; step(); init_req = 0;
    for (int i = 1; i <= 7; i++) step();
    host_on = 0; step(); host_on = 1;
    for (int i = 1; i <= 8; i++) step();
    chk(recover_rst == 0 && recover_cnt == 2, "R3 host off cleared", recover_cnt, 2);
    for (int i = 1; i <= 4; i++) step();
    chk(recover_rst == 1, "R3 third low after clear", recover_rst, 1);

    // R2: interval 0 acts as 1
    tag = "R2";
    interval = 0; init_req = 1; step(); init_req = 0;
    for (int i = 1; i <= 3; i++) begin
      step();
      chk(recover_rst == (i == 3), "R2 zero interval", recover_rst, i == 3);
    end

    // R7: saturation
    tag = "R7";
    interval = 1;
    repeat (60) step();
    chk(recover_cnt == 15, "R7 saturated", recover_cnt, 15);

    // random
    tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      sda_in   = ($urandom % 100) < 30;
      host_on  = ($urandom % 100) < 85;
      wr_done  = ($urandom % 100) < 4;
      init_req = ($urandom % 100) < 2;
      if (($urandom % 50) == 0) interval = TW'(1 + $urandom % 5);
      step();
    end
    init_req = 0; wr_done = 0;
    step();
    done_summary();
  end

  initial void'($urandom(32'd1234));
endmodule